// File: doc/BRIEF.md
# Display Controller Host Register File

This block holds the host-visible storage of an eight-position dot-matrix character display controller. A host drives a slow parallel bus: active-low chip enable, write strobe, read strobe and area select, five address lines and an eight-bit data bus. The block brings these strobes into the system clock domain through synchronisers. It commits a write one edge after it sees the write strobe rise while chip enable is low, and it returns the addressed storage while a read is active.

The storage consists of eight 8-bit character slots, eight per-position flash bits, a 4-bit pointer to a custom glyph, a custom-glyph memory of 16 glyphs with 7 rows of 5 columns each, and an 8-bit control word. Separate read ports let the refresh logic fetch a character slot, its flash bit and any glyph row without involving the bus. A display-initialise input and a self-clearing clear bit in the control word start timed sequences that run for three display-clock ticks. While a sequence or an external self-test is active, the block reports busy, discards host writes and records each discarded write in a sticky error flag.

Top module: `charmap_regs`

## Requirements
- R1: With `bus_fsel_n` low, the flash bits are addressed whatever the value of `bus_addr[4:3]`. `bus_addr[2:0]` selects the position, only data bit 0 is stored, and a read returns that bit in bit 0 with bits 7..1 zero. No other storage changes.
- R2: With `bus_fsel_n` high, `bus_addr[4:3]` selects the area. 2'b11 is the character slots (8 bits). 2'b10 is the control word (8 bits, also on `ctrl_word`). 2'b00 is the glyph pointer (data bits 3..0 stored, read with bits 7..4 zero). 2'b01 is a glyph row (data bits 4..0).
- R3: A write takes effect on the rising edge of `bus_wr_n` only while `bus_ce_n` is low. A write-strobe pulse with `bus_ce_n` high changes nothing.
- R4: `bus_rdata_oe` is high, and `bus_rdata` carries the addressed value, only while both `bus_ce_n` and `bus_rd_n` are low. Otherwise `bus_rdata` is zero.
- R5: Character slot n (address 3'bnnn, position 0 leftmost) keeps all eight bits as written. A bit 7 of 0 marks a 7-bit character code and a bit 7 of 1 marks a glyph index in bits 3..0. The refresh port `disp_char` shows the slot selected by `disp_digit`.
- R6: A glyph-row write stores five column bits into the glyph named by the pointer, at the row given by `bus_addr[2:0]` (3'b000 to 3'b110 are rows 1 to 7). Row code 3'b111 is not stored, reads as zero on the bus and on `gl_cols`, and leaves the other rows unchanged.
- R7: While `init_n` is low, the block sets every character slot to 8'h20, the flash bits to 0, the control word to 8'h00 and `drop_err` to 0. `busy` stays high for the whole hold and for three `dclk_tick` pulses after release. The glyph memory and the glyph pointer are kept.
- R8: Writing the control word with bit 7 = 1 fills the character slots with 8'h20 and clears the flash bits. Bit 7 reads 1 while `busy` stays high for three `dclk_tick` pulses, and then returns to 0 by itself. The other control bits, the glyph pointer and the glyph memory are kept.
- R9: Control bit 5 ignores host writes. A one-cycle `st_done` pulse loads `st_pass` into it.
- R10: `busy` is high during an initialise or clear sequence and whenever `st_active` is high. A host write arriving while busy is discarded and sets `drop_err`, which stays set until the next initialise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_ce_n | input | 1 | Bus chip enable, active low |
| bus_wr_n | input | 1 | Write strobe, commits on its rising edge |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_fsel_n | input | 1 | Selects the flash bits when low |
| bus_addr | input | 5 | Bits 4..3 select the area, bits 2..0 the position or row |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read is active |
| bus_rdata_oe | output | 1 | High while a read drives the bus |
| init_n | input | 1 | Display initialise request, active low |
| dclk_tick | input | 1 | One-cycle pulse per display-clock period |
| st_active | input | 1 | External self-test in progress |
| st_done | input | 1 | Self-test finished pulse |
| st_pass | input | 1 | Self-test result, taken when `st_done` pulses |
| busy | output | 1 | Sequence or self-test running; writes are discarded |
| drop_err | output | 1 | Sticky flag for a discarded write |
| ctrl_word | output | 8 | Current control word |
| disp_digit | input | 3 | Refresh position select |
| disp_char | output | 8 | Character slot at `disp_digit` |
| disp_flash | output | 1 | Flash bit at `disp_digit` |
| gl_sel | input | 4 | Refresh glyph select |
| gl_row | input | 3 | Refresh glyph row select |
| gl_cols | output | 5 | Column bits of the selected glyph row |

## Verification
Every character slot receives a distinct arithmetic value, including one with bit 7 set. A wrong position decode or a dropped high bit therefore shows up as a mismatch. Flash writes are issued with every combination of the two mode bits, which separates a correct area decode from one that lets the mode bits reach the character slots. All 16 glyphs and 7 rows get column patterns derived from the glyph and row numbers. This exposes pointer and row mix-ups, and the unused row code is probed on its own. The control sequences are timed in display-clock ticks and are checked with writes placed inside the busy window, which distinguishes discarded writes from late ones.

// File: rtl/charmap_pkg.sv
package charmap_pkg;

  typedef enum logic [2:0] {
    AREA_FLASH,
    AREA_GPTR,
    AREA_GROW,
    AREA_CHAR,
    AREA_CTRL
  } area_e;

  localparam logic [7:0] BLANK_CODE = 8'h20;

  // Area decode: the flash select overrides the two mode bits.
  function automatic area_e decode_area(input logic fsel_n, input logic [1:0] mode);
    area_e sel;
    if (!fsel_n) begin
      sel = AREA_FLASH;
    end else begin
      case (mode)
        2'b00:   sel = AREA_GPTR;
        2'b01:   sel = AREA_GROW;
        2'b11:   sel = AREA_CHAR;
        default: sel = AREA_CTRL;
      endcase
    end
    return sel;
  endfunction

endpackage

// File: rtl/charmap_busif.sv
module charmap_busif #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic wr_n,
  input  logic rd_n,
  input  logic init_n,
  output logic wr_fire,
  output logic rd_active,
  output logic init_req
);

  localparam int NSIG = 4;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] chain_q [SYNC_STAGES];
  logic [NSIG-1:0] chain_d [SYNC_STAGES];
  logic [NSIG-1:0] sync;
  logic            wr_prev_q, ce_prev_q;

  assign raw = {init_n, rd_n, wr_n, ce_n};

  always_comb begin
    chain_d[0] = raw;
    for (int s = 1; s < SYNC_STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) chain_q[s] <= '1;
      wr_prev_q <= 1'b1;
      ce_prev_q <= 1'b1;
    end else begin
      for (int s = 0; s < SYNC_STAGES; s++) chain_q[s] <= chain_d[s];
      wr_prev_q <= sync[1];
      ce_prev_q <= sync[0];
    end
  end

  assign sync      = chain_q[SYNC_STAGES-1];
  // Rising write strobe while chip enable was low on the previous sample.
  assign wr_fire   = sync[1] & ~wr_prev_q & ~ce_prev_q;
  assign rd_active = ~sync[0] & ~sync[2];
  assign init_req  = ~sync[3];

endmodule

// File: rtl/charmap_seq.sv
module charmap_seq #(
  parameter int TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_req,
  input  logic clr_cmd,
  input  logic tick,
  output logic busy,
  output logic init_clr,
  output logic done
);

  localparam int CW = $clog2(TICKS + 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_HOLD, SQ_WAIT} sq_e;

  sq_e           state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done    = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (clr_cmd) begin
          state_d = SQ_WAIT;
          cnt_d   = '0;
        end
      end
      SQ_HOLD: begin
        cnt_d = '0;
        if (!init_req) state_d = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (tick) begin
          if (cnt_q == CW'(TICKS - 1)) begin
            state_d = SQ_IDLE;
            cnt_d   = '0;
            done    = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
    if (init_req) begin
      state_d = SQ_HOLD;
      cnt_d   = '0;
      done    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy     = (state_q != SQ_IDLE);
  assign init_clr = (state_q == SQ_HOLD);

endmodule

// File: rtl/charmap_store.sv
module charmap_store
  import charmap_pkg::*;
#(
  parameter int DIGITS = 8,
  parameter int GLYPHS = 16,
  parameter int ROWS   = 7,
  parameter int COLS   = 5,
  localparam int DIG_W = $clog2(DIGITS),
  localparam int GA_W  = $clog2(GLYPHS),
  localparam int ROW_W = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  area_e            area,
  input  logic [DIG_W-1:0] pos,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wdata,
  input  logic             init_clr,
  input  logic             clr_cmd,
  input  logic             clr_done,
  input  logic             st_done,
  input  logic             st_pass,
  input  logic [DIG_W-1:0] disp_digit,
  input  logic [GA_W-1:0]  gl_sel,
  input  logic [ROW_W-1:0] gl_row,
  output logic [7:0]       rd_word,
  output logic [7:0]       disp_char,
  output logic             disp_flash,
  output logic [COLS-1:0]  gl_cols,
  output logic [7:0]       ctrl_word
);

  localparam int GI_W    = $clog2(GLYPHS * ROWS + 1);
  localparam int CTRL_RO = 5;
  localparam int CTRL_CL = 7;

  logic [DIGITS-1:0][7:0] char_q, char_d;
  logic [DIGITS-1:0]      flash_q, flash_d;
  logic [GA_W-1:0]        gptr_q, gptr_d;
  logic [7:0]             ctrl_q, ctrl_d;
  logic [COLS-1:0]        glyph_q [GLYPHS*ROWS];

  logic            host_row_ok, disp_row_ok, glyph_we;
  logic [GI_W-1:0] host_gidx, disp_gidx;

  assign host_row_ok = (int'(row) < ROWS);
  assign disp_row_ok = (int'(gl_row) < ROWS);
  assign host_gidx   = GI_W'(gptr_q) * GI_W'(ROWS) + GI_W'(row);
  assign disp_gidx   = GI_W'(gl_sel) * GI_W'(ROWS) + GI_W'(gl_row);
  assign glyph_we    = wr_ok && (area == AREA_GROW) && host_row_ok;

  // Next-state for the resettable storage.
  always_comb begin
    char_d  = char_q;
    flash_d = flash_q;
    gptr_d  = gptr_q;
    ctrl_d  = ctrl_q;
    if (init_clr) begin
      char_d  = {DIGITS{BLANK_CODE}};
      flash_d = '0;
      ctrl_d  = '0;
    end else begin
      if (wr_ok) begin
        case (area)
          AREA_FLASH: flash_d[pos] = wdata[0];
          AREA_GPTR:  gptr_d       = wdata[GA_W-1:0];
          AREA_CHAR:  char_d[pos]  = wdata;
          AREA_CTRL: begin
            ctrl_d          = wdata;
            ctrl_d[CTRL_RO] = ctrl_q[CTRL_RO];
          end
          default: ;
        endcase
      end
      if (clr_cmd) begin
        char_d  = {DIGITS{BLANK_CODE}};
        flash_d = '0;
      end
      if (clr_done) ctrl_d[CTRL_CL] = 1'b0;
      if (st_done)  ctrl_d[CTRL_RO] = st_pass;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q  <= {DIGITS{BLANK_CODE}};
      flash_q <= '0;
      gptr_q  <= '0;
      ctrl_q  <= '0;
    end else begin
      char_q  <= char_d;
      flash_q <= flash_d;
      gptr_q  <= gptr_d;
      ctrl_q  <= ctrl_d;
    end
  end

  // Glyph memory: write-enabled array, not reset.
  always_ff @(posedge clk) begin
    if (glyph_we) glyph_q[host_gidx] <= wdata[COLS-1:0];
  end

  // Host read multiplexer.
  always_comb begin
    rd_word = '0;
    case (area)
      AREA_FLASH: rd_word[0]        = flash_q[pos];
      AREA_GPTR:  rd_word[GA_W-1:0] = gptr_q;
      AREA_GROW:  if (host_row_ok) rd_word[COLS-1:0] = glyph_q[host_gidx];
      AREA_CHAR:  rd_word           = char_q[pos];
      AREA_CTRL:  rd_word           = ctrl_q;
      default:    rd_word           = '0;
    endcase
  end

  assign disp_char  = char_q[disp_digit];
  assign disp_flash = flash_q[disp_digit];
  assign gl_cols    = disp_row_ok ? glyph_q[disp_gidx] : '0;
  assign ctrl_word  = ctrl_q;

endmodule

// File: rtl/charmap_regs.sv
module charmap_regs
  import charmap_pkg::*;
#(
  parameter int DIGITS      = 8,
  parameter int GLYPHS      = 16,
  parameter int ROWS        = 7,
  parameter int COLS        = 5,
  parameter int SEQ_TICKS   = 3,
  parameter int SYNC_STAGES = 2,
  localparam int DIG_W      = $clog2(DIGITS),
  localparam int GA_W       = $clog2(GLYPHS),
  localparam int ROW_W      = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_ce_n,
  input  logic             bus_wr_n,
  input  logic             bus_rd_n,
  input  logic             bus_fsel_n,
  input  logic [4:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             bus_rdata_oe,
  input  logic             init_n,
  input  logic             dclk_tick,
  input  logic             st_active,
  input  logic             st_done,
  input  logic             st_pass,
  output logic             busy,
  output logic             drop_err,
  output logic [7:0]       ctrl_word,
  input  logic [DIG_W-1:0] disp_digit,
  output logic [7:0]       disp_char,
  output logic             disp_flash,
  input  logic [GA_W-1:0]  gl_sel,
  input  logic [ROW_W-1:0] gl_row,
  output logic [COLS-1:0]  gl_cols
);

  area_e      area;
  logic       wr_fire, rd_active, init_req;
  logic       seq_busy, init_clr, seq_done;
  logic       wr_ok, clr_cmd;
  logic       err_q, err_d;
  logic [7:0] rd_word;

  charmap_busif #(.SYNC_STAGES(SYNC_STAGES)) u_busif (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (bus_ce_n),
    .wr_n      (bus_wr_n),
    .rd_n      (bus_rd_n),
    .init_n    (init_n),
    .wr_fire   (wr_fire),
    .rd_active (rd_active),
    .init_req  (init_req)
  );

  assign area    = decode_area(bus_fsel_n, bus_addr[4:3]);
  assign busy    = seq_busy | st_active;
  assign wr_ok   = wr_fire & ~busy;
  assign clr_cmd = wr_ok & (area == AREA_CTRL) & bus_wdata[7];

  charmap_seq #(.TICKS(SEQ_TICKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_req (init_req),
    .clr_cmd  (clr_cmd),
    .tick     (dclk_tick),
    .busy     (seq_busy),
    .init_clr (init_clr),
    .done     (seq_done)
  );

  charmap_store #(
    .DIGITS (DIGITS),
    .GLYPHS (GLYPHS),
    .ROWS   (ROWS),
    .COLS   (COLS)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ok      (wr_ok),
    .area       (area),
    .pos        (bus_addr[DIG_W-1:0]),
    .row        (bus_addr[ROW_W-1:0]),
    .wdata      (bus_wdata),
    .init_clr   (init_clr),
    .clr_cmd    (clr_cmd),
    .clr_done   (seq_done),
    .st_done    (st_done),
    .st_pass    (st_pass),
    .disp_digit (disp_digit),
    .gl_sel     (gl_sel),
    .gl_row     (gl_row),
    .rd_word    (rd_word),
    .disp_char  (disp_char),
    .disp_flash (disp_flash),
    .gl_cols    (gl_cols),
    .ctrl_word  (ctrl_word)
  );

  // Sticky record of discarded writes, cleared by initialise.
  always_comb begin
    err_d = err_q | (wr_fire & busy);
    if (init_clr) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign drop_err     = err_q;
  assign bus_rdata_oe = rd_active;
  assign bus_rdata    = rd_active ? rd_word : 8'h00;

endmodule

// File: rtl/charmap_regs_chk.sv
module charmap_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_fire,
  input logic       busy,
  input logic       init_clr,
  input logic       seq_done,
  input logic       st_done,
  input logic       drop_err,
  input logic [7:0] ctrl_word
);

  assert_drop_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && busy && !init_clr) |=> drop_err);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_err && !init_clr) |=> drop_err);

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drop_err) |-> $past(wr_fire && busy));

  assert_ro_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_done && !init_clr) |=> $stable(ctrl_word[5]));

  assert_init_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> (ctrl_word == 8'h00 && !drop_err));

  assert_clear_selfreset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !init_clr) |=> !ctrl_word[7]);

  assert_busy_holds_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !init_clr && !seq_done && !st_done) |=> $stable(ctrl_word));

endmodule

bind charmap_regs charmap_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_fire   (wr_fire),
  .busy      (busy),
  .init_clr  (init_clr),
  .seq_done  (seq_done),
  .st_done   (st_done),
  .drop_err  (drop_err),
  .ctrl_word (ctrl_word)
);

// File: tb/charmap_regs_test.sv
`timescale 1ns/1ps
module charmap_regs_test;

  localparam int TICK_DIV    = 20;
  localparam int CYCLE_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n, bus_ce_n, bus_wr_n, bus_rd_n, bus_fsel_n;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       bus_rdata_oe, init_n, dclk_tick, st_active, st_done, st_pass;
  logic       busy, drop_err, disp_flash;
  logic [7:0] ctrl_word, disp_char;
  logic [2:0] disp_digit, gl_row;
  logic [3:0] gl_sel;
  logic [4:0] gl_cols;

  int n_chk  = 0;
  int n_fail = 0;
  int tick_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  charmap_regs uut (.*);

  initial dclk_tick = 1'b0;
  always @(posedge clk) begin
    tick_cnt  <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    dclk_tick <= (tick_cnt == TICK_DIV - 1);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic fs, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_fsel_n = fs; bus_addr = a; bus_wdata = d; bus_ce_n = 1'b0;
    repeat (3) @(negedge clk); bus_wr_n = 1'b0;
    repeat (3) @(negedge clk); bus_wr_n = 1'b1;
    repeat (3) @(negedge clk); bus_ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic put_noce(input logic fs, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_fsel_n = fs; bus_addr = a; bus_wdata = d; bus_ce_n = 1'b1;
    repeat (3) @(negedge clk); bus_wr_n = 1'b0;
    repeat (3) @(negedge clk); bus_wr_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic get_raw(input logic fs, input logic [4:0] a, input logic ce_v, input logic rd_v,
                         output logic [7:0] d, output logic oe);
    @(negedge clk);
    bus_fsel_n = fs; bus_addr = a; bus_ce_n = ce_v; bus_rd_n = rd_v;
    repeat (3) @(negedge clk);
    d = bus_rdata; oe = bus_rdata_oe;
    bus_ce_n = 1'b1; bus_rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic peek_char(input int pos, output logic [7:0] c, output logic f);
    disp_digit = 3'(pos);
    #1;
    c = disp_char; f = disp_flash;
  endtask

  function automatic logic [7:0] cval(int p);
    return 8'((p * 53 + 17) % 256);
  endfunction

  function automatic logic [4:0] gcol(int g, int r);
    return 5'((g * 7 + r * 3 + 1) % 32);
  endfunction

  function automatic logic fbit(int p);
    return (p % 3 == 0);
  endfunction

  initial begin
    #(CYCLE_LIMIT * 5.0);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv, exp_ctrl;
    logic       oe, fv;
    int         ticks;
    bit         seen;
    logic       b7;

    rst_n = 1'b0; bus_ce_n = 1'b1; bus_wr_n = 1'b1; bus_rd_n = 1'b1; bus_fsel_n = 1'b1;
    bus_addr = '0; bus_wdata = '0; init_n = 1'b1; st_active = 1'b0; st_done = 1'b0;
    st_pass = 1'b0; disp_digit = '0; gl_sel = '0; gl_row = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state
    check("R10 reset busy", busy, 0);
    check("R10 reset drop_err", drop_err, 0);
    check("R7 reset ctrl", ctrl_word, 8'h00);
    check("R4 reset oe", bus_rdata_oe, 0);
    check("R4 reset rdata", bus_rdata, 8'h00);
    for (int p = 0; p < 8; p++) begin
      peek_char(p, rv, fv);
      check("R7 reset char blank", rv, 8'h20);
      check("R7 reset flash", fv, 0);
    end

    // Character slots
    for (int p = 0; p < 8; p++) put(1'b1, {2'b11, 3'(p)}, cval(p));
    for (int p = 0; p < 8; p++) begin
      peek_char(p, rv, fv);
      check("R5 refresh char", rv, cval(p));
      get_raw(1'b1, {2'b11, 3'(p)}, 1'b0, 1'b0, rv, oe);
      check("R2 char readback", rv, cval(p));
      check("R4 oe during read", oe, 1);
    end

    // Flash bits with every mode-bit combination
    for (int p = 0; p < 8; p++) put(1'b0, {2'(p), 3'(p)}, {7'h55, fbit(p)});
    for (int p = 0; p < 8; p++) begin
      peek_char(p, rv, fv);
      check("R1 flash refresh", fv, fbit(p));
      check("R1 char untouched by flash", rv, cval(p));
      get_raw(1'b0, {2'(p + 1), 3'(p)}, 1'b0, 1'b0, rv, oe);
      check("R1 flash readback", rv, {7'b0, fbit(p)});
    end

    // Glyph pointer and glyph rows
    for (int g = 0; g < 16; g++) begin
      put(1'b1, 5'b00_000, {4'hA, 4'(g)});
      get_raw(1'b1, 5'b00_101, 1'b0, 1'b0, rv, oe);
      check("R2 glyph pointer readback", rv, {4'h0, 4'(g)});
      for (int r = 0; r < 7; r++) put(1'b1, {2'b01, 3'(r)}, {3'b111, gcol(g, r)});
    end
    for (int g = 0; g < 16; g++) begin
      put(1'b1, 5'b00_000, 8'(g));
      for (int r = 0; r < 7; r++) begin
        get_raw(1'b1, {2'b01, 3'(r)}, 1'b0, 1'b0, rv, oe);
        check("R6 glyph row readback", rv, {3'b0, gcol(g, r)});
        gl_sel = 4'(g); gl_row = 3'(r); #1;
        check("R6 glyph refresh", gl_cols, gcol(g, r));
      end
    end
    put(1'b1, 5'b01_111, 8'h1F);
    get_raw(1'b1, 5'b01_111, 1'b0, 1'b0, rv, oe);
    check("R6 row code 7 reads zero", rv, 8'h00);
    get_raw(1'b1, 5'b01_110, 1'b0, 1'b0, rv, oe);
    check("R6 row 7 intact", rv, {3'b0, gcol(15, 6)});
    gl_sel = 4'd15; gl_row = 3'd7; #1;
    check("R6 refresh row code 7", gl_cols, 5'h00);

    // Control word, read-only bit 5
    put(1'b1, 5'b10_000, 8'h3C);
    check("R9 host write skips bit5", ctrl_word, 8'h1C);
    get_raw(1'b1, 5'b10_011, 1'b0, 1'b0, rv, oe);
    check("R2 ctrl readback", rv, 8'h1C);
    put(1'b1, 5'b10_000, 8'h45);
    exp_ctrl = 8'h45;
    check("R2 ctrl word port", ctrl_word, exp_ctrl);

    // Chip enable gating of writes and reads
    put_noce(1'b1, 5'b11_000, 8'h99);
    peek_char(0, rv, fv);
    check("R3 write without ce ignored", rv, cval(0));
    get_raw(1'b1, 5'b11_000, 1'b1, 1'b0, rv, oe);
    check("R4 no oe without ce", oe, 0);
    check("R4 rdata zero without ce", rv, 8'h00);
    get_raw(1'b1, 5'b11_000, 1'b0, 1'b1, rv, oe);
    check("R4 no oe without rd", oe, 0);

    // Self-test busy window and result bit
    @(negedge clk); st_active = 1'b1;
    @(negedge clk);
    check("R10 busy during self-test", busy, 1);
    put(1'b1, 5'b11_010, 8'h77);
    peek_char(2, rv, fv);
    check("R10 write dropped while busy", rv, cval(2));
    check("R10 drop_err set", drop_err, 1);
    st_pass = 1'b1;
    @(negedge clk); st_done = 1'b1;
    @(negedge clk); st_done = 1'b0; st_active = 1'b0;
    @(negedge clk);
    exp_ctrl = exp_ctrl | 8'h20;
    check("R9 st_done loads result", ctrl_word, exp_ctrl);
    put(1'b1, 5'b10_000, 8'h00);
    check("R9 bit5 survives host write", ctrl_word, 8'h20);
    check("R10 drop_err sticky", drop_err, 1);

    // Initialise sequence
    @(negedge clk); init_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 busy during init", busy, 1);
    check("R7 init clears ctrl", ctrl_word, 8'h00);
    check("R7 init clears drop_err", drop_err, 0);
    for (int p = 0; p < 8; p++) begin
      peek_char(p, rv, fv);
      check("R7 init blanks char", rv, 8'h20);
      check("R7 init clears flash", fv, 0);
    end
    do @(negedge clk); while (!dclk_tick);
    init_n = 1'b1;
    ticks = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy) break;
      if (dclk_tick) ticks++;
    end
    check("R7 init tail length in ticks", ticks, 3);
    get_raw(1'b1, 5'b00_000, 1'b0, 1'b0, rv, oe);
    check("R7 glyph pointer kept", rv, 8'h0F);

    // Clear command
    put(1'b1, 5'b11_000, 8'h41);
    put(1'b1, 5'b11_101, 8'h42);
    put(1'b1, 5'b11_111, 8'h43);
    put(1'b0, 5'b00_001, 8'h01);
    put(1'b0, 5'b00_110, 8'h01);
    put(1'b1, 5'b10_000, 8'h1B);
    @(negedge clk);
    bus_fsel_n = 1'b1; bus_addr = 5'b10_000; bus_wdata = 8'h9B; bus_ce_n = 1'b0;
    repeat (3) @(negedge clk); bus_wr_n = 1'b0;
    repeat (3) @(negedge clk); bus_wr_n = 1'b1;
    ticks = 0; seen = 0; b7 = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (busy) begin
        if (!seen) b7 = ctrl_word[7];
        seen = 1;
        if (dclk_tick) ticks++;
      end else if (seen) break;
    end
    bus_ce_n = 1'b1;
    check("R8 clear bit reads 1 while busy", b7, 1);
    check("R8 clear length in ticks", ticks, 3);
    check("R8 clear bit self-resets, others kept", ctrl_word, 8'h1B);
    for (int p = 0; p < 8; p++) begin
      peek_char(p, rv, fv);
      check("R8 clear blanks char", rv, 8'h20);
      check("R8 clear zeroes flash", fv, 0);
    end
    get_raw(1'b1, 5'b01_010, 1'b0, 1'b0, rv, oe);
    check("R8 glyph memory kept", rv, {3'b0, gcol(15, 2)});

    // Write arriving inside the clear window
    check("R10 drop_err clear before", drop_err, 0);
    put(1'b1, 5'b10_000, 8'h9B);
    check("R10 busy after clear start", busy, 1);
    put(1'b1, 5'b11_011, 8'h41);
    check("R10 drop during clear", drop_err, 1);
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    peek_char(3, rv, fv);
    check("R10 dropped char write absent", rv, 8'h20);
    check("R8 second clear ends", ctrl_word, 8'h1B);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule